// File: doc/BRIEF.md
# Ping-Pong DMA Channel Controller

This block is one DMA channel that moves data between one fixed peripheral FIFO address and two memory buffers, used in turn. Software writes the peripheral address. For each buffer it writes a start address and a count. The count register also carries four upper memory address bits. Software then sets the buffer enable bits and the run bit in a mode register. That register is written through two offsets: one sets bits and the other clears them.

While running, the channel issues one transfer request per data item on a valid/ready interface. Each request carries the memory address, the peripheral address, the direction and the item width. After each accepted request the active buffer's count drops by one and its address advances by the item width in bytes. When a buffer's count reaches zero, the channel marks that buffer done, disables it, and switches to the other buffer. It keeps going if the other buffer is enabled and waits otherwise. Clearing the run bit stops the channel, and a halt flag confirms the stop. A done flag can raise an interrupt.

Top module: `dmac_pingpong`

## Requirements
- R1: After reset the mode register reads 0x00000040, with only the halt flag (bit 6) set. All other registers read zero, and `irq` and `xfer_valid` are low.
- R2: Writing offset 0x00 ORs the data into the mode register and writing offset 0x04 clears the bits that are 1 in the data. Offset 0x00 reads the mode back. The active-buffer bit (4) and the halt flag (bit 6) ignore writes, and bits 14 and 31:20 always read 0.
- R3: Offset 0x08 holds the peripheral address. Offsets 0x0C and 0x14 hold the buffer 0 and buffer 1 addresses, and offsets 0x10 and 0x18 hold their counts (bits 15:0) and upper address bits (19:16). Reads return the current, updated address and count.
- R4: The channel drives `xfer_valid` when the run bit (5) is set and the active buffer's enable bit (bit 0 for buffer 0, bit 2 for buffer 1) is set and its count is nonzero. `xfer_mem_addr` is {upper bits, address}. Each accepted request lowers the count by 1 and raises the address by 1, 2 or 4 bytes for a width field (bits 10:9) of 0, 1 or 2; code 3 steps by 4.
- R5: In the cycle after the active buffer's count is zero while it is enabled and the run bit is set, the channel does three things. It sets that buffer's done bit (bit 1 for buffer 0, bit 3 for buffer 1), clears that buffer's enable bit, and inverts the active-buffer bit. It then continues with the other buffer if that buffer is enabled.
- R6: If the newly active buffer is not enabled, no request is issued while the run bit stays set. Setting that buffer's enable bit resumes the transfers.
- R7: Clearing the run bit drops `xfer_valid` at the same edge, and no count changes after that. The halt flag reads 1 from one cycle after the run bit reads 0 and stays 1 while stopped. It clears one cycle after the run bit is set.
- R8: `irq` equals the interrupt enable bit (7) ANDed with the OR of the two done bits. It falls once software clears both done bits.
- R9: `xfer_dir` follows mode bit 12 (0 means memory to peripheral) and `xfer_periph_addr` follows the peripheral address register.
- R10: `resid_bytes` equals the active buffer's count shifted left by 0, 1 or 2 for width codes 0, 1 and 2 or 3.
- R11: An enabled buffer that has a count of zero is completed as in R5 without issuing any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| xfer_valid | output | 1 | Transfer request pending |
| xfer_ready | input | 1 | Transfer accepted at this edge when valid |
| xfer_mem_addr | output | 36 | Memory address of the request |
| xfer_periph_addr | output | 32 | Peripheral FIFO address |
| xfer_dir | output | 1 | 0 means memory to peripheral, 1 means peripheral to memory |
| xfer_width | output | 2 | Item width code |
| resid_bytes | output | 18 | Bytes remaining in the active buffer |
| irq | output | 1 | Done interrupt |

## Verification
The bench targets the buffer hand-over. A design with an off-by-one there would issue one request too many or one too few, or would start the second buffer at the wrong address. It also targets a buffer left disabled after the switch: a faulty channel would keep issuing requests instead of waiting. Other stimulus covers a zero count, a stop in the middle of a buffer while the ready input is held low, and clearing the two done bits one at a time. Random widths, counts, addresses and ready patterns show whether the address step or the width shift is wrong in any width. Each accepted request is compared against a queue of expected addresses.

// File: rtl/dmac_pkg.sv
// Package: bit positions, offsets and width helpers for the ping-pong DMA channel.
// Assumes a 32-bit register bus and byte offsets on 5 bits.
package dmac_pkg;
    localparam int MB_BE0  = 0;
    localparam int MB_D0   = 1;
    localparam int MB_BE1  = 2;
    localparam int MB_D1   = 3;
    localparam int MB_AB   = 4;
    localparam int MB_GO   = 5;
    localparam int MB_HALT = 6;
    localparam int MB_IE   = 7;
    localparam int MB_DW   = 9;
    localparam int MB_DR   = 12;

    localparam logic [31:0] MODE_RW_MASK  = 32'h000F_BFAF;
    localparam logic [31:0] MODE_RST_VAL  = 32'h0000_0040;

    localparam logic [4:0] OFS_MSET  = 5'h00;
    localparam logic [4:0] OFS_MCLR  = 5'h04;
    localparam logic [4:0] OFS_PADDR = 5'h08;
    localparam logic [4:0] OFS_S0    = 5'h0C;
    localparam logic [4:0] OFS_C0    = 5'h10;
    localparam logic [4:0] OFS_S1    = 5'h14;
    localparam logic [4:0] OFS_C1    = 5'h18;

    // log2 of the item size in bytes for a width code
    function automatic logic [1:0] width_shift(input logic [1:0] code);
        return (code == 2'd0) ? 2'd0 : (code == 2'd1) ? 2'd1 : 2'd2;
    endfunction
endpackage

// File: rtl/dmac_bufslot.sv
// One buffer descriptor: a running address, a count and upper address bits.
// Assumes a software write wins over an engine step in the same cycle.
module dmac_bufslot #(
    parameter int CNT_W = 16,
    parameter int HI_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_start,
    input  logic                    wr_count,
    input  logic [31:0]             start_wdata,
    input  logic [CNT_W+HI_W-1:0]   cnt_wdata,
    input  logic                    step_en,
    input  logic [2:0]              step_bytes,
    output logic [31:0]             start_q,
    output logic [CNT_W-1:0]        count_q,
    output logic [HI_W-1:0]         hi_q
);
    // address register: load on write, advance per accepted item
    always_ff @(posedge clk) begin
        if (!rst_n)        start_q <= '0;
        else if (wr_start) start_q <= start_wdata;
        else if (step_en)  start_q <= start_q + 32'(step_bytes);
    end

    // count and upper bits: load on write, count down per accepted item
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            hi_q    <= '0;
        end else if (wr_count) begin
            count_q <= cnt_wdata[CNT_W-1:0];
            hi_q    <= cnt_wdata[CNT_W+HI_W-1:CNT_W];
        end else if (step_en) begin
            count_q <= count_q - 1'b1;
        end
    end

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |-> (count_q != '0));

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !wr_count) |=> (count_q == CNT_W'($past(count_q) - 1'b1)));
endmodule

// File: rtl/dmac_ctrl.sv
// Mode register with set/clear writes and the buffer alternation sequencer.
// Assumes a request completes in the cycle it is accepted, so stopping abandons nothing.
module dmac_ctrl
    import dmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_we,
    input  logic        clr_we,
    input  logic [31:0] wdata,
    input  logic [1:0]  cnt_zero,
    input  logic        xfer_ready,
    output logic [31:0] mode_q,
    output logic        xfer_valid,
    output logic [1:0]  step,
    output logic        irq
);
    logic        ab, be_act, zero_act, go, fire, finish;
    logic [31:0] mode_d;

    // decode the active buffer state and the request/finish conditions
    always_comb begin
        ab         = mode_q[MB_AB];
        go         = mode_q[MB_GO];
        be_act     = ab ? mode_q[MB_BE1] : mode_q[MB_BE0];
        zero_act   = cnt_zero[ab];
        xfer_valid = go && be_act && !zero_act;
        fire       = xfer_valid && xfer_ready;
        step       = {fire && ab, fire && !ab};
        finish     = go && be_act && zero_act;
    end

    // next mode: buffer hand-over first, then software set/clear, then halt flag
    always_comb begin
        mode_d = mode_q;
        if (finish) begin
            if (ab) begin
                mode_d[MB_D1]  = 1'b1;
                mode_d[MB_BE1] = 1'b0;
            end else begin
                mode_d[MB_D0]  = 1'b1;
                mode_d[MB_BE0] = 1'b0;
            end
            mode_d[MB_AB] = !ab;
        end
        if (set_we) mode_d = mode_d | (wdata & MODE_RW_MASK);
        if (clr_we) mode_d = mode_d & ~(wdata & MODE_RW_MASK);
        mode_d[MB_HALT] = !mode_q[MB_GO];
    end

    // mode register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_RST_VAL;
        else        mode_q <= mode_d;
    end

    // interrupt from done flags
    assign irq = mode_q[MB_IE] && (mode_q[MB_D0] || mode_q[MB_D1]);

    assert_halt_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_q[MB_GO]) |=> mode_q[MB_HALT]);

    assert_ab_only_on_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(mode_q[MB_AB]));

    assert_done0_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !ab && !clr_we) |=> mode_q[MB_D0]);

    assert_done1_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && ab && !clr_we) |=> mode_q[MB_D1]);

    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step));
endmodule

// File: rtl/dmac_pingpong.sv
// Top: register decode and read mux, two buffer slots, the sequencer and the request port.
// Assumes one register access per cycle; reads are combinational on reg_addr.
module dmac_pingpong
    import dmac_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int HI_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [4:0]            reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic                  xfer_valid,
    input  logic                  xfer_ready,
    output logic [32+HI_W-1:0]    xfer_mem_addr,
    output logic [31:0]           xfer_periph_addr,
    output logic                  xfer_dir,
    output logic [1:0]            xfer_width,
    output logic [CNT_W+1:0]      resid_bytes,
    output logic                  irq
);
    localparam int CW    = CNT_W + HI_W;
    localparam int PAD_W = 32 - CW;

    logic [1:0]       wr_s, wr_c, step, cnt_zero;
    logic [31:0]      start_q [2];
    logic [CNT_W-1:0] cnt_q   [2];
    logic [HI_W-1:0]  hi_q    [2];
    logic [31:0]      mode_q, paddr_q;
    logic [1:0]       wsh;
    logic             ab;

    // write strobes per register
    always_comb begin
        wr_s = {reg_wr && reg_addr == OFS_S1, reg_wr && reg_addr == OFS_S0};
        wr_c = {reg_wr && reg_addr == OFS_C1, reg_wr && reg_addr == OFS_C0};
    end

    // peripheral address register
    always_ff @(posedge clk) begin
        if (!rst_n)                                paddr_q <= '0;
        else if (reg_wr && reg_addr == OFS_PADDR)  paddr_q <= reg_wdata;
    end

    assign wsh = width_shift(mode_q[MB_DW +: 2]);

    for (genvar g = 0; g < 2; g++) begin : g_slot
        dmac_bufslot #(.CNT_W(CNT_W), .HI_W(HI_W)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_start    (wr_s[g]),
            .wr_count    (wr_c[g]),
            .start_wdata (reg_wdata),
            .cnt_wdata   (reg_wdata[CW-1:0]),
            .step_en     (step[g]),
            .step_bytes  (3'd1 << wsh),
            .start_q     (start_q[g]),
            .count_q     (cnt_q[g]),
            .hi_q        (hi_q[g])
        );
        assign cnt_zero[g] = (cnt_q[g] == '0);
    end

    dmac_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_we     (reg_wr && reg_addr == OFS_MSET),
        .clr_we     (reg_wr && reg_addr == OFS_MCLR),
        .wdata      (reg_wdata),
        .cnt_zero   (cnt_zero),
        .xfer_ready (xfer_ready),
        .mode_q     (mode_q),
        .xfer_valid (xfer_valid),
        .step       (step),
        .irq        (irq)
    );

    // request port and residue from the active buffer
    always_comb begin
        ab               = mode_q[MB_AB];
        xfer_mem_addr    = {hi_q[ab], start_q[ab]};
        xfer_periph_addr = paddr_q;
        xfer_dir         = mode_q[MB_DR];
        xfer_width       = mode_q[MB_DW +: 2];
        resid_bytes      = {2'b00, cnt_q[ab]} << wsh;
    end

    // register read mux
    always_comb begin
        case (reg_addr)
            OFS_MSET:  reg_rdata = mode_q;
            OFS_PADDR: reg_rdata = paddr_q;
            OFS_S0:    reg_rdata = start_q[0];
            OFS_C0:    reg_rdata = {{PAD_W{1'b0}}, hi_q[0], cnt_q[0]};
            OFS_S1:    reg_rdata = start_q[1];
            OFS_C1:    reg_rdata = {{PAD_W{1'b0}}, hi_q[1], cnt_q[1]};
            default:   reg_rdata = '0;
        endcase
    end

    assert_irq_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (mode_q[MB_D0] || mode_q[MB_D1]));
endmodule

// File: tb/test_dmac_pingpong.sv
module test_dmac_pingpong;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        xfer_valid, xfer_ready = 1'b0, xfer_dir, irq;
    logic [35:0] xfer_mem_addr;
    logic [31:0] xfer_periph_addr;
    logic [1:0]  xfer_width;
    logic [17:0] resid_bytes;

    int checks = 0, fails = 0;
    int rdy_mode = 0;
    logic [35:0] expq[$];
    logic        exp_dir = 1'b0;
    logic [31:0] exp_paddr = '0;
    bit          done_flag = 0;

    dmac_pingpong i_dmac_pingpong (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic int shf(input int dw);
        return (dw == 0) ? 0 : (dw == 1) ? 1 : 2;
    endfunction

    // push expected addresses for one buffer
    task automatic push_buf(input logic [3:0] hi, input logic [31:0] s, input int n, input int dw);
        for (int k = 0; k < n; k++) expq.push_back({hi, s + 32'(k << shf(dw))});
    endtask

    task automatic wait_done(input logic [31:0] mask, input string tag);
        logic [31:0] m;
        bit ok = 0;
        for (int k = 0; k < 3000; k++) begin
            rd(5'h00, m);
            if ((m & 32'hA) == mask) begin ok = 1; break; end
        end
        chk(ok, tag, m & 32'hA, mask);
    endtask

    task automatic stop_all();
        wr(5'h04, 32'hFFFF_FFFF);
        repeat (2) @(negedge clk);
    endtask

    // request monitor and ready driver
    always @(negedge clk) begin
        case (rdy_mode)
            0: xfer_ready = 1'b0;
            1: xfer_ready = 1'($urandom % 2);
            default: xfer_ready = 1'b1;
        endcase
        if (rst_n && xfer_valid && xfer_ready) begin
            if (expq.size() == 0) begin
                chk(0, "R4 unexpected request", 64'(xfer_mem_addr), 0);
            end else begin
                logic [35:0] e;
                e = expq.pop_front();
                chk(xfer_mem_addr == e, "R4 request address", 64'(xfer_mem_addr), 64'(e));
                chk(xfer_dir == exp_dir, "R9 direction", 64'(xfer_dir), 64'(exp_dir));
                chk(xfer_periph_addr == exp_paddr, "R9 peripheral address", 64'(xfer_periph_addr), 64'(exp_paddr));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] m, v;
        int unsigned sd;
        sd = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'h00, m); chk(m == 32'h40, "R1 mode reset", m, 32'h40);
        rd(5'h10, m); chk(m == 0, "R1 count0 reset", m, 0);
        rd(5'h14, m); chk(m == 0, "R1 start1 reset", m, 0);
        chk(!irq && !xfer_valid, "R1 irq/valid reset", {irq, xfer_valid}, 0);

        // R2 set/clear semantics and protected bits
        wr(5'h00, 32'h0000_0090);
        rd(5'h00, m); chk(m == 32'hC0, "R2 set IE, AB ignored", m, 32'hC0);
        wr(5'h04, 32'h0000_00C0);
        rd(5'h00, m); chk(m == 32'h40, "R2 clear IE, HALT kept", m, 32'h40);
        wr(5'h00, 32'hFFF0_4000);
        rd(5'h00, m); chk(m == 32'h40, "R2 reserved bits read zero", m, 32'h40);

        // R3/R4/R5/R9 main run: 32-bit, peripheral to memory, both buffers
        exp_paddr = 32'hA000_0010; exp_dir = 1'b1;
        wr(5'h08, exp_paddr);
        wr(5'h0C, 32'h0000_1000); wr(5'h10, 32'h0002_0003);
        wr(5'h14, 32'h0000_2000); wr(5'h18, 32'h0005_0002);
        rd(5'h08, m); chk(m == exp_paddr, "R3 peripheral readback", m, exp_paddr);
        push_buf(4'h2, 32'h1000, 3, 2); push_buf(4'h5, 32'h2000, 2, 2);
        rdy_mode = 1;
        wr(5'h00, 32'h0000_14A5);
        wait_done(32'hA, "R5 both done");
        repeat (2) @(negedge clk);
        chk(expq.size() == 0, "R4 all requests issued", expq.size(), 0);
        rd(5'h00, m); chk(m == 32'h14AA, "R5 mode after run", m, 32'h14AA);
        rd(5'h10, m); chk(m == 32'h0002_0000, "R3 count0 readback", m, 32'h0002_0000);
        rd(5'h18, m); chk(m == 32'h0005_0000, "R3 count1 readback", m, 32'h0005_0000);
        rd(5'h0C, m); chk(m == 32'h100C, "R3 start0 advanced", m, 32'h100C);
        rd(5'h14, m); chk(m == 32'h2008, "R3 start1 advanced", m, 32'h2008);
        chk(irq, "R8 irq with done", irq, 1);

        // R8 clearing done bits one at a time
        wr(5'h04, 32'h2);
        #1 chk(irq, "R8 irq with D1 left", irq, 1);
        wr(5'h04, 32'h8);
        #1 chk(!irq, "R8 irq after both cleared", irq, 0);
        wr(5'h04, 32'h80); wr(5'h00, 32'h2);
        #1 chk(!irq, "R8 no irq with IE clear", irq, 0);
        wr(5'h00, 32'h80);
        #1 chk(irq, "R8 irq when IE set", irq, 1);
        stop_all();

        // R10 residue, R6 idle on disabled buffer, 16-bit memory to peripheral
        exp_dir = 1'b0;
        rdy_mode = 0;
        wr(5'h0C, 32'h0000_3000); wr(5'h10, 32'h0000_0005);
        wr(5'h14, 32'h0000_4000); wr(5'h18, 32'h0001_0001);
        wr(5'h00, 32'h0000_0221);
        #1 chk(resid_bytes == 18'd10, "R10 residue 16-bit", resid_bytes, 10);
        push_buf(4'h0, 32'h3000, 5, 1);
        rdy_mode = 1;
        wait_done(32'h2, "R5 buffer0 done");
        rd(5'h00, m); chk(m[4] == 1'b1, "R5 active buffer toggled", m[4], 1);
        v = 0;
        for (int k = 0; k < 6; k++) begin @(negedge clk); if (xfer_valid) v++; end
        chk(v == 0, "R6 idle while buffer1 disabled", v, 0);
        rd(5'h00, m); chk(m[3] == 1'b0, "R6 no done on disabled buffer", m[3], 0);
        push_buf(4'h1, 32'h4000, 1, 1);
        wr(5'h00, 32'h4);
        wait_done(32'hA, "R6 resume on enable");
        chk(expq.size() == 0, "R6 requests drained", expq.size(), 0);
        stop_all();

        // R7 halt handshake mid-buffer
        rdy_mode = 0;
        wr(5'h0C, 32'h0000_5000); wr(5'h10, 32'd100);
        wr(5'h00, 32'h0000_0021);
        rd(5'h00, m); chk(m[6] == 1'b0 && xfer_valid, "R7 running, halt clear", {m[6], xfer_valid}, 2'b01);
        wr(5'h04, 32'h20);
        #1 chk(!xfer_valid, "R7 valid drops on stop", xfer_valid, 0);
        rd(5'h00, m); chk(m[6] == 1'b1, "R7 halt reported", m[6], 1);
        repeat (3) @(negedge clk);
        rd(5'h00, m); chk(m[6] == 1'b1, "R7 halt held", m[6], 1);
        rd(5'h10, m); chk(m == 32'd100, "R7 count unchanged", m, 100);
        stop_all();

        // R11 zero count completes immediately
        wr(5'h10, 32'h0);
        wr(5'h00, 32'h0000_0021);
        wait_done(32'h2, "R11 zero count done");
        rd(5'h00, m); chk(m[4] == 1'b1 && expq.size() == 0, "R11 toggled, no request", m[4], 1);
        stop_all();

        // random runs over widths, counts, addresses and ready patterns
        rdy_mode = 1;
        for (int it = 0; it < 10; it++) begin
            int dw, c0, c1;
            logic [31:0] s0, s1;
            logic [3:0] h0, h1;
            logic a;
            dw = $urandom % 3; c0 = 1 + $urandom % 7; c1 = 1 + $urandom % 7;
            s0 = $urandom & 32'hFFFF_FFF0; s1 = $urandom & 32'hFFFF_FFF0;
            h0 = 4'($urandom); h1 = 4'($urandom);
            exp_dir = 1'($urandom); exp_paddr = $urandom;
            wr(5'h08, exp_paddr);
            wr(5'h0C, s0); wr(5'h10, {12'h0, h0, 16'(c0)});
            wr(5'h14, s1); wr(5'h18, {12'h0, h1, 16'(c1)});
            rd(5'h00, m); a = m[4];
            if (!a) begin push_buf(h0, s0, c0, dw); push_buf(h1, s1, c1, dw); end
            else    begin push_buf(h1, s1, c1, dw); push_buf(h0, s0, c0, dw); end
            wr(5'h00, 32'h25 | (32'(dw) << 9) | (32'(exp_dir) << 12));
            wait_done(32'hA, "R5 random both done");
            chk(expq.size() == 0, "R4 random drained", expq.size(), 0);
            rd(5'h0C, m); v = s0 + 32'(c0 << shf(dw));
            chk(m == v, "R4 random start0 step", m, v);
            rd(5'h18, m); chk(m == {12'h0, h1, 16'h0}, "R3 random count1", m, {12'h0, h1, 16'h0});
            stop_all();
            expq.delete();
        end

        done_flag = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule